// File: doc/BRIEF.md
# JTAG Debug Transport Module

This block is a JTAG test access port that carries a debug transport. It is clocked by TCK, runs the sixteen-state TAP controller from TMS, and shifts both instruction and data registers LSB first, with TDI sampled and TDO presented in the same TCK cycle. A 5-bit instruction register selects one of four data paths. The first is a fixed 32-bit identification word. The second is a 32-bit transport control/status word. The third is a debug-module access register. Every other code selects a one-bit bypass.

A scan of the access register carries an address, a 32-bit data word and a 2-bit operation. When the scan completes it can launch one read or write toward a debug module through a valid/ready request channel. The matching response comes back on a valid-qualified channel. Read data is held and appears in the next access scan. That scan also reports the status of the previous operation. If a scan overlaps an operation that is still in flight, or the module reports a failure, the block records a sticky error. The sticky error blocks further requests until software clears it through the control/status register.

Top module: `dbg_jtag_dtm`

## Requirements
- R1: While `trst_ni` is low at a TCK rising edge, the controller enters Test-Logic-Reset, the instruction becomes 0x01, `dmi_req_valid_o` is 0 and `tdo_o` is 0. After release, one TMS-low edge reaches Run-Test/Idle, and a 32-bit data scan returns the identification word.
- R2: Five or more consecutive TCK rising edges with TMS high put the controller in Test-Logic-Reset from any state, and the instruction returns to 0x01.
- R3: With instruction 0x01, a 32-bit data scan shifts out the `IdCode` parameter LSB first, whatever is shifted in.
- R4: Instruction 0x10 selects the control/status register and 0x11 selects the access register. Any other code selects a 1-bit bypass that captures 0, so an 8-bit scan returns the input delayed by one bit.
- R5: The control/status register captures the following fields: 1 in bits 3:0, the address width (7) in bits 9:4, the sticky status in bits 11:10, and the idle hint (1) in bits 14:12. All other bits are 0.
- R6: The access register is {address[6:0], data[31:0], op[1:0]}, with op in bits 1:0 and data in bits 33:2. On capture, op holds the status (0 success, 2 failed, 3 busy) and the address field holds the address of the last issued request.
- R7: An Update-DR of the access register with op 1 (read) or 2 (write) issues exactly one request, but only when nothing is outstanding and no error is sticky. The request carries the scanned address, data and op. Valid and all request fields hold steady until ready is seen.
- R8: Response data for a read is latched when `dmi_rsp_valid_i` is seen, and it is shifted out in bits 33:2 of the next access scan. That scan may carry op 0 (nop).
- R9: An access-register Capture-DR or Update-DR while a request is outstanding reports busy (3) and makes busy sticky. While any error is sticky, no request is issued.
- R10: A response with op 2 (failed) makes status 2 sticky.
- R11: A control/status register update with bit 16 set clears the sticky status. Without that update, the sticky status never changes.
- R12: A response that arrives in the same cycle as an access-register capture is still too late for that scan, so the scan reports busy. The response data is nevertheless latched and appears after the sticky status is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck_i | input | 1 | Test clock; all state changes on its rising edge |
| trst_ni | input | 1 | Active-low test reset, sampled on TCK |
| tms_i | input | 1 | Test mode select |
| tdi_i | input | 1 | Serial data in |
| tdo_o | output | 1 | Serial data out, LSB of the active shift register; 0 outside shift states |
| dmi_req_valid_o | output | 1 | Request to the debug module is pending |
| dmi_req_ready_i | input | 1 | Debug module accepts the request |
| dmi_req_addr_o | output | 7 | Request address |
| dmi_req_data_o | output | 32 | Write data |
| dmi_req_op_o | output | 2 | 1 read, 2 write |
| dmi_rsp_valid_i | input | 1 | Response from the debug module is present |
| dmi_rsp_data_i | input | 32 | Read data of the response |
| dmi_rsp_op_i | input | 2 | Response status, 0 success, 2 failed |

## Verification
The sharp corner is the meeting of two events: a response from the debug module and a fresh access scan's Capture-DR. The bench provokes it by setting the model latency to one cycle and starting the next scan immediately after Update-DR, so the response and the capture fall on the same TCK edge. It expects the scan to report busy and the busy status to stay sticky. After a dmireset, a nop scan must still show the read data that arrived in that colliding cycle. A second case adds one idle cycle between the scans, and there the scan must report success.

// File: rtl/dtm_pkg.sv
// Shared types and codes for the JTAG debug transport.
// Assumes: one TCK domain; the operation and status codes are fixed by the transport.
package dtm_pkg;

    typedef enum logic [3:0] {
        TAP_RESET, TAP_IDLE,
        TAP_SEL_DR, TAP_CAP_DR, TAP_SH_DR, TAP_EX1_DR, TAP_PAUSE_DR, TAP_EX2_DR, TAP_UPD_DR,
        TAP_SEL_IR, TAP_CAP_IR, TAP_SH_IR, TAP_EX1_IR, TAP_PAUSE_IR, TAP_EX2_IR, TAP_UPD_IR
    } tap_state_e;

    typedef enum logic [1:0] {
        PATH_BYPASS, PATH_IDENT, PATH_CTRL, PATH_ACCESS
    } dr_path_e;

    localparam logic [1:0] OP_NOP   = 2'd0;
    localparam logic [1:0] OP_READ  = 2'd1;
    localparam logic [1:0] OP_WRITE = 2'd2;

    localparam logic [1:0] ST_OK    = 2'd0;
    localparam logic [1:0] ST_FAIL  = 2'd2;
    localparam logic [1:0] ST_BUSY  = 2'd3;

endpackage

// File: rtl/dtm_tap_fsm.sv
// TAP controller: the sixteen-state machine that TMS walks on each TCK edge.
// Assumes: trst_ni is synchronous to tck_i.
module dtm_tap_fsm
    import dtm_pkg::*;
(
    input  logic       tck_i,
    input  logic       trst_ni,
    input  logic       tms_i,
    output tap_state_e state_o
);

    tap_state_e state_q, state_d;

    // Next state from the current state and TMS.
    always_comb begin
        case (state_q)
            TAP_RESET:    state_d = tms_i ? TAP_RESET  : TAP_IDLE;
            TAP_IDLE:     state_d = tms_i ? TAP_SEL_DR : TAP_IDLE;
            TAP_SEL_DR:   state_d = tms_i ? TAP_SEL_IR : TAP_CAP_DR;
            TAP_CAP_DR:   state_d = tms_i ? TAP_EX1_DR : TAP_SH_DR;
            TAP_SH_DR:    state_d = tms_i ? TAP_EX1_DR : TAP_SH_DR;
            TAP_EX1_DR:   state_d = tms_i ? TAP_UPD_DR : TAP_PAUSE_DR;
            TAP_PAUSE_DR: state_d = tms_i ? TAP_EX2_DR : TAP_PAUSE_DR;
            TAP_EX2_DR:   state_d = tms_i ? TAP_UPD_DR : TAP_SH_DR;
            TAP_UPD_DR:   state_d = tms_i ? TAP_SEL_DR : TAP_IDLE;
            TAP_SEL_IR:   state_d = tms_i ? TAP_RESET  : TAP_CAP_IR;
            TAP_CAP_IR:   state_d = tms_i ? TAP_EX1_IR : TAP_SH_IR;
            TAP_SH_IR:    state_d = tms_i ? TAP_EX1_IR : TAP_SH_IR;
            TAP_EX1_IR:   state_d = tms_i ? TAP_UPD_IR : TAP_PAUSE_IR;
            TAP_PAUSE_IR: state_d = tms_i ? TAP_EX2_IR : TAP_PAUSE_IR;
            TAP_EX2_IR:   state_d = tms_i ? TAP_UPD_IR : TAP_SH_IR;
            TAP_UPD_IR:   state_d = tms_i ? TAP_SEL_DR : TAP_IDLE;
            default:      state_d = TAP_RESET;
        endcase
    end

    // State register with synchronous test reset.
    always_ff @(posedge tck_i) begin
        if (!trst_ni) state_q <= TAP_RESET;
        else          state_q <= state_d;
    end

    assign state_o = state_q;

    AST_TMS_FIVE_RESET: assert property (@(posedge tck_i) disable iff (!trst_ni)
        (tms_i && $past(tms_i) && $past(tms_i, 2) && $past(tms_i, 3) && $past(tms_i, 4))
        |=> state_q == TAP_RESET); // R2

endmodule

// File: rtl/dtm_ir.sv
// Instruction register: a capture/shift stage and a held instruction.
// Assumes: shifts LSB first; Test-Logic-Reset restores the identification instruction.
module dtm_ir
    import dtm_pkg::*;
#(
    parameter int            IrW       = 5,
    parameter logic [IrW-1:0] ResetInstr = IrW'(1)
) (
    input  logic           tck_i,
    input  logic           trst_ni,
    input  logic           tdi_i,
    input  tap_state_e     state_i,
    output logic [IrW-1:0] instr_o,
    output logic           sh_lsb_o
);

    localparam logic [IrW-1:0] CapPattern = IrW'(1);

    logic [IrW-1:0] sh_q;
    logic [IrW-1:0] instr_q;

    // Capture stage: load the fixed pattern, then shift TDI in at the top.
    always_ff @(posedge tck_i) begin
        if (!trst_ni)                     sh_q <= '0;
        else if (state_i == TAP_CAP_IR)   sh_q <= CapPattern;
        else if (state_i == TAP_SH_IR)    sh_q <= {tdi_i, sh_q[IrW-1:1]};
    end

    // Held instruction: updated on Update-IR, restored in Test-Logic-Reset.
    always_ff @(posedge tck_i) begin
        if (!trst_ni)                     instr_q <= ResetInstr;
        else if (state_i == TAP_RESET)    instr_q <= ResetInstr;
        else if (state_i == TAP_UPD_IR)   instr_q <= sh_q;
    end

    assign instr_o  = instr_q;
    assign sh_lsb_o = sh_q[0];

    AST_IR_DEFAULT: assert property (@(posedge tck_i) disable iff (!trst_ni)
        (state_i == TAP_RESET) |=> instr_q == ResetInstr); // R2

endmodule

// File: rtl/dtm_dmi_ctrl.sv
// Access engine: launches debug-module requests, tracks the outstanding one,
// latches read data and keeps the sticky status.
// Assumes: a response arrives only after its request was accepted.
module dtm_dmi_ctrl
    import dtm_pkg::*;
#(
    parameter int AddrW = 7,
    parameter int DataW = 32
) (
    input  logic             tck_i,
    input  logic             trst_ni,
    input  logic             cap_access_i,
    input  logic             upd_access_i,
    input  logic [AddrW-1:0] upd_addr_i,
    input  logic [DataW-1:0] upd_data_i,
    input  logic [1:0]       upd_op_i,
    input  logic             clear_i,
    output logic             req_valid_o,
    input  logic             req_ready_i,
    output logic [AddrW-1:0] req_addr_o,
    output logic [DataW-1:0] req_data_o,
    output logic [1:0]       req_op_o,
    input  logic             rsp_valid_i,
    input  logic [DataW-1:0] rsp_data_i,
    input  logic [1:0]       rsp_op_i,
    output logic [1:0]       cap_status_o,
    output logic [1:0]       sticky_o,
    output logic [DataW-1:0] rdata_o,
    output logic [AddrW-1:0] last_addr_o
);

    logic             req_q, wait_q;
    logic [AddrW-1:0] addr_q;
    logic [DataW-1:0] data_q, rdata_q;
    logic [1:0]       op_q, sticky_q;
    logic             pending, launch, rsp_take;

    assign pending  = req_q | wait_q;
    assign rsp_take = wait_q & rsp_valid_i;
    assign launch   = upd_access_i & ~pending & (sticky_q == ST_OK) &
                      ((upd_op_i == OP_READ) | (upd_op_i == OP_WRITE));

    // Request channel and response wait: one operation in flight at most.
    always_ff @(posedge tck_i) begin
        if (!trst_ni) begin
            req_q   <= 1'b0;
            wait_q  <= 1'b0;
            addr_q  <= '0;
            data_q  <= '0;
            op_q    <= OP_NOP;
            rdata_q <= '0;
        end else begin
            if (req_q && req_ready_i) begin
                req_q  <= 1'b0;
                wait_q <= 1'b1;
            end
            if (rsp_take) begin
                wait_q <= 1'b0;
                if (op_q == OP_READ) rdata_q <= rsp_data_i;
            end
            if (launch) begin
                req_q  <= 1'b1;
                addr_q <= upd_addr_i;
                data_q <= upd_data_i;
                op_q   <= upd_op_i;
            end
        end
    end

    // Sticky status: first error wins, only a clear removes it.
    always_ff @(posedge tck_i) begin
        if (!trst_ni) begin
            sticky_q <= ST_OK;
        end else if (clear_i) begin
            sticky_q <= ST_OK;
        end else if (sticky_q == ST_OK) begin
            if ((cap_access_i || upd_access_i) && pending) sticky_q <= ST_BUSY;
            else if (rsp_take && (rsp_op_i == ST_FAIL))    sticky_q <= ST_FAIL;
        end
    end

    // Status presented in the op field at capture time.
    always_comb begin
        if (sticky_q != ST_OK) cap_status_o = sticky_q;
        else if (pending)      cap_status_o = ST_BUSY;
        else                   cap_status_o = ST_OK;
    end

    assign req_valid_o = req_q;
    assign req_addr_o  = addr_q;
    assign req_data_o  = data_q;
    assign req_op_o    = op_q;
    assign sticky_o    = sticky_q;
    assign rdata_o     = rdata_q;
    assign last_addr_o = addr_q;

    AST_REQ_HOLD: assert property (@(posedge tck_i) disable iff (!trst_ni)
        (req_valid_o && !req_ready_i) |=> (req_valid_o && $stable(req_addr_o) &&
        $stable(req_data_o) && $stable(req_op_o))); // R7
    AST_ONE_OUTSTANDING: assert property (@(posedge tck_i) disable iff (!trst_ni)
        $onehot0({req_q, wait_q})); // R7
    AST_NO_REQ_STICKY: assert property (@(posedge tck_i) disable iff (!trst_ni)
        $rose(req_valid_o) |-> ($past(sticky_q) == ST_OK)); // R9
    AST_OVERLAP_BUSY: assert property (@(posedge tck_i) disable iff (!trst_ni)
        ((cap_access_i || upd_access_i) && pending) |=> (sticky_q != ST_OK)); // R9
    AST_STICKY_HOLD: assert property (@(posedge tck_i) disable iff (!trst_ni)
        ((sticky_q != ST_OK) && !clear_i) |=> (sticky_q == $past(sticky_q))); // R11
    AST_READ_LATCH: assert property (@(posedge tck_i) disable iff (!trst_ni)
        (rsp_take && (op_q == OP_READ)) |=> (rdata_o == $past(rsp_data_i))); // R8

endmodule

// File: rtl/dbg_jtag_dtm.sv
// JTAG debug transport: TAP, instruction decode, shared data shift register
// and the access engine toward a debug module.
// Assumes: everything runs on TCK; the DM side is in the same clock domain.
module dbg_jtag_dtm
    import dtm_pkg::*;
#(
    parameter int          IrW      = 5,
    parameter int          AddrW    = 7,
    parameter int          DataW    = 32,
    parameter logic [31:0] IdCode   = 32'h1DB0_A0C3,
    parameter logic [2:0]  IdleHint = 3'd1
) (
    input  logic             tck_i,
    input  logic             trst_ni,
    input  logic             tms_i,
    input  logic             tdi_i,
    output logic             tdo_o,
    output logic             dmi_req_valid_o,
    input  logic             dmi_req_ready_i,
    output logic [AddrW-1:0] dmi_req_addr_o,
    output logic [DataW-1:0] dmi_req_data_o,
    output logic [1:0]       dmi_req_op_o,
    input  logic             dmi_rsp_valid_i,
    input  logic [DataW-1:0] dmi_rsp_data_i,
    input  logic [1:0]       dmi_rsp_op_i
);

    localparam int             AccW     = AddrW + DataW + 2;
    localparam int             DrW      = (AccW > 32) ? AccW : 32;
    localparam logic [IrW-1:0] InIdent  = IrW'(5'h01);
    localparam logic [IrW-1:0] InCtrl   = IrW'(5'h10);
    localparam logic [IrW-1:0] InAccess = IrW'(5'h11);
    localparam int             ClearBit = 16;

    tap_state_e       state;
    logic [IrW-1:0]   instr;
    logic             ir_lsb;
    dr_path_e         path;
    logic [DrW-1:0]   dr_q, dr_shifted, dr_cap;
    logic [1:0]       cap_status, sticky;
    logic [DataW-1:0] rdata;
    logic [AddrW-1:0] last_addr;
    logic [31:0]      ctrl_word;
    logic             cap_access, upd_access, clear;

    dtm_tap_fsm u_fsm (
        .tck_i   (tck_i),
        .trst_ni (trst_ni),
        .tms_i   (tms_i),
        .state_o (state)
    );

    dtm_ir #(
        .IrW        (IrW),
        .ResetInstr (InIdent)
    ) u_ir (
        .tck_i    (tck_i),
        .trst_ni  (trst_ni),
        .tdi_i    (tdi_i),
        .state_i  (state),
        .instr_o  (instr),
        .sh_lsb_o (ir_lsb)
    );

    // Decode the held instruction into a data path.
    always_comb begin
        if (instr == InIdent)       path = PATH_IDENT;
        else if (instr == InCtrl)   path = PATH_CTRL;
        else if (instr == InAccess) path = PATH_ACCESS;
        else                        path = PATH_BYPASS;
    end

    assign ctrl_word = {17'd0, IdleHint, sticky, 6'(AddrW), 4'd1};

    // Value loaded into the shift register at Capture-DR.
    always_comb begin
        dr_cap = '0;
        case (path)
            PATH_IDENT:  dr_cap[31:0]     = IdCode;
            PATH_CTRL:   dr_cap[31:0]     = ctrl_word;
            PATH_ACCESS: dr_cap[AccW-1:0] = {last_addr, rdata, cap_status};
            default:     dr_cap           = '0;
        endcase
    end

    // One shift step: move right and insert TDI at the top of the active length.
    always_comb begin
        dr_shifted = dr_q >> 1;
        case (path)
            PATH_IDENT, PATH_CTRL: dr_shifted[31]     = tdi_i;
            PATH_ACCESS:           dr_shifted[AccW-1] = tdi_i;
            default:               dr_shifted[0]      = tdi_i;
        endcase
    end

    // Shared data shift register.
    always_ff @(posedge tck_i) begin
        if (!trst_ni)                   dr_q <= '0;
        else if (state == TAP_CAP_DR)   dr_q <= dr_cap;
        else if (state == TAP_SH_DR)    dr_q <= dr_shifted;
    end

    assign cap_access = (state == TAP_CAP_DR) && (path == PATH_ACCESS);
    assign upd_access = (state == TAP_UPD_DR) && (path == PATH_ACCESS);
    assign clear      = (state == TAP_UPD_DR) && (path == PATH_CTRL) && dr_q[ClearBit];

    dtm_dmi_ctrl #(
        .AddrW (AddrW),
        .DataW (DataW)
    ) u_acc (
        .tck_i        (tck_i),
        .trst_ni      (trst_ni),
        .cap_access_i (cap_access),
        .upd_access_i (upd_access),
        .upd_addr_i   (dr_q[AccW-1:DataW+2]),
        .upd_data_i   (dr_q[DataW+1:2]),
        .upd_op_i     (dr_q[1:0]),
        .clear_i      (clear),
        .req_valid_o  (dmi_req_valid_o),
        .req_ready_i  (dmi_req_ready_i),
        .req_addr_o   (dmi_req_addr_o),
        .req_data_o   (dmi_req_data_o),
        .req_op_o     (dmi_req_op_o),
        .rsp_valid_i  (dmi_rsp_valid_i),
        .rsp_data_i   (dmi_rsp_data_i),
        .rsp_op_i     (dmi_rsp_op_i),
        .cap_status_o (cap_status),
        .sticky_o     (sticky),
        .rdata_o      (rdata),
        .last_addr_o  (last_addr)
    );

    // Serial output: LSB of whichever register is shifting.
    always_comb begin
        if (state == TAP_SH_IR)      tdo_o = ir_lsb;
        else if (state == TAP_SH_DR) tdo_o = dr_q[0];
        else                         tdo_o = 1'b0;
    end

    AST_RESET_QUIET: assert property (@(posedge tck_i)
        !trst_ni |=> !dmi_req_valid_o); // R1

endmodule

// File: tb/sim_dbg_jtag_dtm.sv
module sim_dbg_jtag_dtm;

    localparam logic [31:0] IDC = 32'h1DB0_A0C3;
    localparam int AW = 7;
    localparam int AccW = 41;

    logic tck = 1'b0;
    always #10 tck = ~tck;

    logic        trst_n, tms, tdi, tdo;
    logic        req_valid, req_ready;
    logic [6:0]  req_addr;
    logic [31:0] req_data;
    logic [1:0]  req_op;
    logic        rsp_valid = 1'b0;
    logic [31:0] rsp_data = '0;
    logic [1:0]  rsp_op = '0;

    int checks = 0;
    int errors = 0;
    int lat = 3;
    int cnt = 0;
    int fires = 0;
    logic busy = 1'b0;
    logic [31:0] mem [8];

    dbg_jtag_dtm u0 (
        .tck_i(tck), .trst_ni(trst_n), .tms_i(tms), .tdi_i(tdi), .tdo_o(tdo),
        .dmi_req_valid_o(req_valid), .dmi_req_ready_i(req_ready),
        .dmi_req_addr_o(req_addr), .dmi_req_data_o(req_data), .dmi_req_op_o(req_op),
        .dmi_rsp_valid_i(rsp_valid), .dmi_rsp_data_i(rsp_data), .dmi_rsp_op_i(rsp_op)
    );

    // Debug-module model: fixed latency, address 0x7F answers "failed".
    always @(posedge tck) begin
        rsp_valid <= 1'b0;
        if (!trst_n) begin
            busy <= 1'b0;
            cnt  <= 0;
        end else if (busy) begin
            if (cnt <= 1) begin rsp_valid <= 1'b1; busy <= 1'b0; end
            else cnt <= cnt - 1;
        end else if (req_valid && req_ready) begin
            busy  <= 1'b1;
            cnt   <= lat;
            fires <= fires + 1;
            if (req_op == 2'd2 && req_addr != 7'h7F) mem[req_addr[2:0]] <= req_data;
            rsp_data <= mem[req_addr[2:0]];
            rsp_op   <= (req_addr == 7'h7F) ? 2'd2 : 2'd0;
        end
    end

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic step(input logic m, input logic d, output logic o);
        @(negedge tck);
        tms = m;
        tdi = d;
        #2;
        o = tdo;
        @(posedge tck);
    endtask

    task automatic idle(input int k);
        logic o;
        for (int i = 0; i < k; i++) step(1'b0, 1'b0, o);
    endtask

    task automatic set_ir(input logic [4:0] code);
        logic o;
        step(1, 0, o); step(1, 0, o); step(0, 0, o); step(0, 0, o);
        for (int i = 0; i < 5; i++) step(i == 4, code[i], o);
        step(1, 0, o); step(0, 0, o);
    endtask

    task automatic scan_dr(input int len, input logic [63:0] din, output logic [63:0] dout);
        logic o;
        dout = '0;
        step(1, 0, o); step(0, 0, o); step(0, 0, o);
        for (int i = 0; i < len; i++) begin
            step(i == len - 1, din[i], o);
            dout[i] = o;
        end
        step(1, 0, o); step(0, 0, o);
    endtask

    task automatic acc(input logic [6:0] a, input logic [31:0] d, input logic [1:0] op,
                       output logic [6:0] oa, output logic [31:0] od, output logic [1:0] oo);
        logic [63:0] r;
        scan_dr(AccW, {23'd0, a, d, op}, r);
        oo = r[1:0];
        od = r[33:2];
        oa = r[40:34];
    endtask

    task automatic clear_sticky(output logic [63:0] ctrl);
        set_ir(5'h10);
        scan_dr(32, 64'h1_0000, ctrl);
        set_ir(5'h11);
    endtask

    function automatic logic [63:0] ctrl_exp(input logic [1:0] st);
        return {32'd0, 17'd0, 3'd1, st, 6'(AW), 4'd1};
    endfunction

    // {address, data} pairs: write, read back, nop to fetch the data.
    localparam logic [38:0] VEC [4] = '{
        {7'h02, 32'hDEADBEEF},
        {7'h05, 32'h1234_5678},
        {7'h00, 32'h0000_0000},
        {7'h03, 32'hFFFF_FFFF}
    };

    initial begin
        repeat (150000) @(posedge tck);
        checks++;
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [63:0] r;
        logic [6:0]  oa;
        logic [31:0] od;
        logic [1:0]  oo;
        logic        o;
        int          f0;

        tms = 1'b1; tdi = 1'b0; trst_n = 1'b0; req_ready = 1'b1;
        repeat (3) @(posedge tck);
        @(negedge tck);
        chk("R1 tdo in reset", {63'd0, tdo}, 64'd0);
        chk("R1 req_valid in reset", {63'd0, req_valid}, 64'd0);
        trst_n = 1'b1;
        step(0, 0, o);

        // R1/R3: identification after reset, independent of TDI
        scan_dr(32, 64'hFFFF_FFFF, r);
        chk("R1 R3 idcode ones in", r, {32'd0, IDC});
        scan_dr(32, 64'h5A5A_0F0F, r);
        chk("R3 idcode pattern in", r, {32'd0, IDC});

        // R4: bypass
        set_ir(5'h1F);
        scan_dr(8, 64'hA5, r);
        chk("R4 bypass delay", r, 64'h4A);

        // R5: control/status fields
        set_ir(5'h10);
        scan_dr(32, 64'd0, r);
        chk("R5 ctrl word", r, ctrl_exp(2'd0));

        // R2: TMS-high reset restores identification instruction
        set_ir(5'h11);
        for (int i = 0; i < 5; i++) step(1, 0, o);
        step(0, 0, o);
        scan_dr(32, 64'd0, r);
        chk("R2 tms reset idcode", r, {32'd0, IDC});

        // R6/R7/R8: table walk
        set_ir(5'h11);
        lat = 3;
        for (int v = 0; v < 4; v++) begin
            acc(VEC[v][38:32], VEC[v][31:0], 2'd2, oa, od, oo);
            idle(8);
            acc(VEC[v][38:32], 32'd0, 2'd1, oa, od, oo);
            chk("R6 status after write", {62'd0, oo}, 64'd0);
            idle(8);
            acc(7'd0, 32'd0, 2'd0, oa, od, oo);
            chk("R8 read data", {32'd0, od}, {32'd0, VEC[v][31:0]});
            chk("R6 status after read", {62'd0, oo}, 64'd0);
            chk("R6 address field", {57'd0, oa}, {57'd0, VEC[v][38:32]});
        end

        // R7: request held until ready
        req_ready = 1'b0;
        f0 = fires;
        acc(7'h06, 32'hCAFE_0006, 2'd2, oa, od, oo);
        idle(3);
        @(negedge tck);
        chk("R7 valid held", {63'd0, req_valid}, 64'd1);
        chk("R7 fields held", {23'd0, req_addr, req_data, req_op},
            {23'd0, 7'h06, 32'hCAFE_0006, 2'd2});
        req_ready = 1'b1;
        idle(10);
        chk("R7 single request", 64'(fires - f0), 64'd1);
        acc(7'h06, 32'd0, 2'd1, oa, od, oo);
        idle(8);
        acc(7'd0, 32'd0, 2'd0, oa, od, oo);
        chk("R7 written value", {32'd0, od}, 64'hCAFE_0006);

        // R9 boundary: one idle cycle after a latency-1 read is enough
        lat = 1;
        acc(7'h02, 32'd0, 2'd1, oa, od, oo);
        idle(1);
        acc(7'd0, 32'd0, 2'd0, oa, od, oo);
        chk("R9 boundary ok", {62'd0, oo}, 64'd0);
        chk("R8 boundary data", {32'd0, od}, 64'hDEADBEEF);

        // R12: response and capture on the same edge
        acc(7'h05, 32'd0, 2'd1, oa, od, oo);
        acc(7'd0, 32'd0, 2'd0, oa, od, oo);
        chk("R12 collision busy", {62'd0, oo}, 64'd3);
        idle(4);
        acc(7'd0, 32'd0, 2'd0, oa, od, oo);
        chk("R9 busy sticky", {62'd0, oo}, 64'd3);
        clear_sticky(r);
        chk("R5 sticky busy field", r, ctrl_exp(2'd3));
        acc(7'd0, 32'd0, 2'd0, oa, od, oo);
        chk("R11 cleared", {62'd0, oo}, 64'd0);
        chk("R12 data kept", {32'd0, od}, 64'h1234_5678);

        // R9: overlapping write while the first is outstanding is dropped
        lat = 30;
        f0 = fires;
        acc(7'h04, 32'h0000_00A1, 2'd2, oa, od, oo);
        acc(7'h04, 32'h0000_00B2, 2'd2, oa, od, oo);
        chk("R9 overlap busy", {62'd0, oo}, 64'd3);
        idle(40);
        chk("R9 second write suppressed", 64'(fires - f0), 64'd1);
        clear_sticky(r);
        lat = 3;
        acc(7'h04, 32'd0, 2'd1, oa, od, oo);
        idle(8);
        acc(7'd0, 32'd0, 2'd0, oa, od, oo);
        chk("R9 first write only", {32'd0, od}, 64'h0000_00A1);

        // R10: failed response is sticky and blocks requests
        lat = 2;
        acc(7'h7F, 32'd0, 2'd1, oa, od, oo);
        idle(8);
        acc(7'd0, 32'd0, 2'd0, oa, od, oo);
        chk("R10 failed status", {62'd0, oo}, 64'd2);
        f0 = fires;
        acc(7'h01, 32'h77, 2'd2, oa, od, oo);
        chk("R10 still failed", {62'd0, oo}, 64'd2);
        idle(8);
        chk("R10 no request while sticky", 64'(fires - f0), 64'd0);
        clear_sticky(r);
        chk("R5 sticky failed field", r, ctrl_exp(2'd2));
        acc(7'd0, 32'd0, 2'd0, oa, od, oo);
        chk("R11 cleared after fail", {62'd0, oo}, 64'd0);

        // R1: mid-run test reset
        set_ir(5'h11);
        @(negedge tck);
        trst_n = 1'b0;
        tms = 1'b0;
        repeat (2) @(posedge tck);
        @(negedge tck);
        chk("R1 tdo under trst", {63'd0, tdo}, 64'd0);
        chk("R1 valid under trst", {63'd0, req_valid}, 64'd0);
        trst_n = 1'b1;
        step(0, 0, o);
        scan_dr(32, 64'd0, r);
        chk("R1 idcode after trst", r, {32'd0, IDC});

        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule